// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programmable state of an interrupt router and makes it reachable through only two 32-bit bus locations. Software first writes an index into a select register, then reads or writes a data window; the window access lands on whichever internal register the index names. The internal registers are an identifier, a fixed version word, an arbitration word that mirrors the identifier, and a table of routing entries. Each table entry is 64 bits wide and is reached as two 32-bit halves.

The full routing table is exported as a flat vector to the delivery logic, which reads masks, vectors and destinations from it directly. The bus side is a plain single-cycle register port. A write is taken on the rising clock edge. Read data is combinational from the current address, size and stored state. The version word reports the entry count, so the parameter that sets the table depth also sets what software reads back.

Top module: `irq_route_regs`

## Requirements
- R1: An access is accepted only when `bus_size` is 2 (four bytes) and `bus_addr` is 0x00 (select) or 0x10 (window). A write with any other size or address changes no state. A read with any other size or address returns zero.
- R2: The select register is 32 bits wide and resets to zero. A read of offset 0x00 returns the full stored index.
- R3: A window access decodes only bits 7:0 of the select register. Index 0x110 therefore reaches the same register as index 0x10.
- R4: Index 0x00 is the identifier register, which resets to zero. A write to it keeps only bits 27:24 and clears every other bit. A read returns the stored value.
- R5: Index 0x01 returns (NUM_ENTRIES << 16) | 0x11, which is 0x00100011 for 16 entries. Writes to this index are ignored.
- R6: Index 0x02 is read-only and always returns the current identifier value.
- R7: Indices 0x10 to 0x10+2*NUM_ENTRIES-1 reach the routing table. The entry number is (index-0x10)/2. An even index selects bits 31:0 of the entry and an odd index selects bits 63:32.
- R8: A window write to a table half replaces that 32-bit half only. The other half of the same entry is left unchanged.
- R9: Reset loads every table entry with 0x0001_0000_0001_0000, so the mask bit (bit 16) starts set.
- R10: A window read of any index that has no register returns zero, and a window write to such an index changes no state.
- R11: `redir_tbl` shows a table write from the clock edge that accepts it. In the cycle of the write itself, `bus_rdata` still shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | Access size as log2 of the byte count (2 = 32-bit) |
| bus_we | input | 1 | Write enable; taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| redir_tbl | output | NUM_ENTRIES*64 | All routing entries; entry p occupies bits p*64+63 : p*64 |

## Verification
Two functions can fall in the same cycle: a window write that updates a table half, and a window read of that same half. The bench drives a window write, then samples `bus_rdata` and `redir_tbl` before the accepting edge. Both must still hold the old half at that point. After the edge, both must show the new value. A second pair of functions shares one cycle: decoding the select index and updating it. Changing the select register and reading the window in the following cycle shows that the window follows the new index one edge after the select write.

// File: rtl/irq_route_pkg.sv
// Shared constants for the indirect-access interrupt routing register file.
// Assumes an 8-bit byte-offset bus and 32-bit data.
package irq_route_pkg;
    localparam int BUS_AW = 8;
    localparam int DW     = 32;
    localparam int IDX_W  = 8;

    localparam logic [BUS_AW-1:0] OFF_SEL   = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_WIN   = 8'h10;
    localparam logic [1:0]        SIZE_WORD = 2'd2;

    localparam logic [IDX_W-1:0] IDX_ID  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARB = 8'h02;
    localparam logic [IDX_W-1:0] IDX_TBL = 8'h10;

    localparam logic [63:0]   ENTRY_RST     = 64'h0001_0000_0001_0000;
    localparam logic [DW-1:0] ID_FIELD_MASK = 32'h0F00_0000;
endpackage

// File: rtl/irq_bus_decode.sv
// Bus decode: qualifies an access by offset and size.
// Assumes bus_size is log2 of the byte count; only 32-bit accesses qualify.
module irq_bus_decode
    import irq_route_pkg::*;
(
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    output logic              sel_hit,
    output logic              win_hit,
    output logic              sel_wr,
    output logic              win_wr
);
    // Flag a qualified access to each of the two locations.
    always_comb begin
        sel_hit = (bus_size == SIZE_WORD) && (bus_addr == OFF_SEL);
        win_hit = (bus_size == SIZE_WORD) && (bus_addr == OFF_WIN);
        sel_wr  = sel_hit && bus_we;
        win_wr  = win_hit && bus_we;
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
// Select register and identifier register.
// Assumes the window decode uses only bits 7:0 of the select value.
module irq_ctrl_regs
    import irq_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic          win_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sel_q,
    output logic [DW-1:0] id_q
);
    // Store the index written to the select location.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= wdata;
    end

    // Store the identifier field; all bits outside it are cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && sel_q[IDX_W-1:0] == IDX_ID)
            id_q <= wdata & ID_FIELD_MASK;
    end
endmodule

// File: rtl/irq_redir_table.sv
// Routing table: NUM_ENTRIES 64-bit entries, written and read as 32-bit halves.
// Assumes 2 <= NUM_ENTRIES and 0x10 + 2*NUM_ENTRIES <= 256.
module irq_redir_table
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_wr,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rd_word,
    output logic                     rd_hit,
    output logic [NUM_ENTRIES*64-1:0] tbl_flat
);
    localparam int PIN_W = $clog2(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] TBL_SPAN = IDX_W'(2 * NUM_ENTRIES);

    logic [DW-1:0] lo_w [NUM_ENTRIES];
    logic [DW-1:0] hi_w [NUM_ENTRIES];

    genvar p;
    generate
        for (p = 0; p < NUM_ENTRIES; p++) begin : g_ent
            localparam logic [IDX_W-1:0] LO_IDX = IDX_TBL + IDX_W'(2 * p);
            localparam logic [IDX_W-1:0] HI_IDX = IDX_TBL + IDX_W'(2 * p + 1);
            logic [DW-1:0] lo_q;
            logic [DW-1:0] hi_q;

            // Load one half of this entry when the index names it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= ENTRY_RST[31:0];
                    hi_q <= ENTRY_RST[63:32];
                end else if (win_wr && idx == LO_IDX) begin
                    lo_q <= wdata;
                end else if (win_wr && idx == HI_IDX) begin
                    hi_q <= wdata;
                end
            end

            assign lo_w[p]             = lo_q;
            assign hi_w[p]             = hi_q;
            assign tbl_flat[p*64 +: 64] = {hi_q, lo_q};
        end
    endgenerate

    logic [IDX_W-1:0] offs;
    logic [PIN_W-1:0] pin;

    // Map the index to an entry and half for the read port.
    always_comb begin
        offs    = idx - IDX_TBL;
        pin     = PIN_W'(offs >> 1);
        rd_hit  = (idx >= IDX_TBL) && (offs < TBL_SPAN);
        rd_word = '0;
        if (rd_hit) rd_word = idx[0] ? hi_w[pin] : lo_w[pin];
    end
endmodule

// File: rtl/irq_route_regs.sv
// Top: select/window register file for an interrupt router.
// Assumes a single-cycle bus; reads are combinational, writes take effect at the edge.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                bus_addr,
    input  logic [1:0]                bus_size,
    input  logic                      bus_we,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [NUM_ENTRIES*64-1:0] redir_tbl
);
    localparam logic [DW-1:0] VER_VAL = (DW'(NUM_ENTRIES) << 16) | 32'h11;

    logic          sel_hit, win_hit, sel_wr, win_wr;
    logic [DW-1:0] sel_q, id_q, tbl_word;
    logic          tbl_hit;

    irq_bus_decode u_dec (
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_we   (bus_we),
        .sel_hit  (sel_hit),
        .win_hit  (win_hit),
        .sel_wr   (sel_wr),
        .win_wr   (win_wr)
    );

    irq_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_wr (sel_wr),
        .win_wr (win_wr),
        .wdata  (bus_wdata),
        .sel_q  (sel_q),
        .id_q   (id_q)
    );

    irq_redir_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_wr   (win_wr),
        .idx      (sel_q[IDX_W-1:0]),
        .wdata    (bus_wdata),
        .rd_word  (tbl_word),
        .rd_hit   (tbl_hit),
        .tbl_flat (redir_tbl)
    );

    // Select the read source from the location and the stored index.
    always_comb begin
        bus_rdata = '0;
        if (sel_hit) begin
            bus_rdata = sel_q;
        end else if (win_hit) begin
            case (sel_q[IDX_W-1:0])
                IDX_ID:  bus_rdata = id_q;
                IDX_VER: bus_rdata = VER_VAL;
                IDX_ARB: bus_rdata = id_q;
                default: bus_rdata = tbl_hit ? tbl_word : '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_regs_chk.sv
// Assertion checker for irq_route_regs, attached by bind below.
// Assumes it sees the top ports plus the internal select register.
module irq_route_regs_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [7:0]                bus_addr,
    input logic [1:0]                bus_size,
    input logic                      bus_we,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic [NUM_ENTRIES*64-1:0] redir_tbl,
    input logic [31:0]               sel_q
);
    localparam logic [31:0] VER_EXP = (32'(NUM_ENTRIES) << 16) | 32'h11;

    // R1 and R8: without an accepted window write, the table must hold.
    p_tbl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFF_WIN && bus_size == SIZE_WORD) |=> $stable(redir_tbl));

    // R1: a read of an unaccepted location returns zero.
    p_bad_rd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size != SIZE_WORD || (bus_addr != OFF_SEL && bus_addr != OFF_WIN)) |-> bus_rdata == '0);

    // R2: an accepted select write is stored in full.
    p_sel_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_SEL && bus_size == SIZE_WORD) |=> sel_q == $past(bus_wdata));

    // R5: the version index always reads the fixed word.
    p_ver_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_WIN && bus_size == SIZE_WORD && sel_q[7:0] == IDX_VER) |-> bus_rdata == VER_EXP);

    // R4 and R6: identifier and arbitration reads carry only the identifier field.
    p_id_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_WIN && bus_size == SIZE_WORD && (sel_q[7:0] == IDX_ID || sel_q[7:0] == IDX_ARB))
        |-> (bus_rdata & ~ID_FIELD_MASK) == '0);

    // R9: the cycle after reset, every entry holds the masked reset value.
    p_reset_tbl_r9: assert property (@(posedge clk)
        !rst_n |=> redir_tbl == {NUM_ENTRIES{ENTRY_RST}});
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .redir_tbl (redir_tbl),
    .sel_q     (sel_q)
);

// File: tb/tb_irq_route_regs.sv
// Bench for irq_route_regs: a vector table walk, then directed reset and same-cycle tests.
module tb_irq_route_regs;
    localparam int N  = 16;
    localparam int NV = 44;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 2'd2, 32'h0000_0001, 4'd5},  // R5
        '{1'b0, 8'h10, 2'd2, 32'h0010_0011, 4'd5},  // R5
        '{1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF, 4'd5},  // R5
        '{1'b0, 8'h10, 2'd2, 32'h0010_0011, 4'd5},  // R5
        '{1'b1, 8'h00, 2'd2, 32'h0000_0000, 4'd4},  // R4
        '{1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF, 4'd4},  // R4
        '{1'b0, 8'h10, 2'd2, 32'h0F00_0000, 4'd4},  // R4
        '{1'b1, 8'h00, 2'd2, 32'h0000_0002, 4'd6},  // R6
        '{1'b0, 8'h10, 2'd2, 32'h0F00_0000, 4'd6},  // R6
        '{1'b1, 8'h10, 2'd2, 32'h0000_0000, 4'd6},  // R6
        '{1'b0, 8'h10, 2'd2, 32'h0F00_0000, 4'd6},  // R6
        '{1'b0, 8'h00, 2'd2, 32'h0000_0002, 4'd2},  // R2
        '{1'b1, 8'h00, 2'd2, 32'h0000_0010, 4'd7},  // R7
        '{1'b0, 8'h10, 2'd2, 32'h0001_0000, 4'd9},  // R9
        '{1'b1, 8'h10, 2'd2, 32'h0000_0031, 4'd7},  // R7
        '{1'b0, 8'h10, 2'd2, 32'h0000_0031, 4'd7},  // R7
        '{1'b1, 8'h00, 2'd2, 32'h0000_0011, 4'd8},  // R8
        '{1'b0, 8'h10, 2'd2, 32'h0001_0000, 4'd8},  // R8
        '{1'b1, 8'h10, 2'd2, 32'hAB00_0000, 4'd7},  // R7
        '{1'b0, 8'h10, 2'd2, 32'hAB00_0000, 4'd7},  // R7
        '{1'b1, 8'h00, 2'd2, 32'h0000_0010, 4'd8},  // R8
        '{1'b0, 8'h10, 2'd2, 32'h0000_0031, 4'd8},  // R8
        '{1'b1, 8'h00, 2'd2, 32'h0000_002F, 4'd7},  // R7
        '{1'b1, 8'h10, 2'd2, 32'h1234_5678, 4'd7},  // R7
        '{1'b0, 8'h10, 2'd2, 32'h1234_5678, 4'd7},  // R7
        '{1'b1, 8'h00, 2'd2, 32'h0000_002E, 4'd8},  // R8
        '{1'b0, 8'h10, 2'd2, 32'h0001_0000, 4'd8},  // R8
        '{1'b1, 8'h00, 2'd2, 32'h0000_0030, 4'd10}, // R10
        '{1'b1, 8'h10, 2'd2, 32'h0000_DEAD, 4'd10}, // R10
        '{1'b0, 8'h10, 2'd2, 32'h0000_0000, 4'd10}, // R10
        '{1'b1, 8'h00, 2'd2, 32'h0000_0003, 4'd10}, // R10
        '{1'b0, 8'h10, 2'd2, 32'h0000_0000, 4'd10}, // R10
        '{1'b1, 8'h00, 2'd2, 32'h0000_0110, 4'd3},  // R3
        '{1'b0, 8'h10, 2'd2, 32'h0000_0031, 4'd3},  // R3
        '{1'b0, 8'h00, 2'd2, 32'h0000_0110, 4'd2},  // R2
        '{1'b1, 8'h10, 2'd1, 32'h0000_FFFF, 4'd1},  // R1
        '{1'b1, 8'h00, 2'd2, 32'h0000_0010, 4'd1},  // R1
        '{1'b0, 8'h10, 2'd2, 32'h0000_0031, 4'd1},  // R1
        '{1'b1, 8'h04, 2'd2, 32'h0000_0055, 4'd1},  // R1
        '{1'b0, 8'h04, 2'd2, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 8'h10, 2'd0, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 8'h00, 2'd2, 32'h0000_0010, 4'd1},  // R1
        '{1'b1, 8'h00, 2'd3, 32'h0000_0000, 4'd1},  // R1
        '{1'b0, 8'h00, 2'd2, 32'h0000_0010, 4'd1}   // R1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N*64-1:0]   redir_tbl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_route_regs #(.NUM_ENTRIES(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .redir_tbl (redir_tbl)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge; a read is sampled mid-cycle.
    task automatic access(input logic we, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
        #5;
        if (!we) check(req, {32'h0, bus_rdata}, {32'h0, exp});
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_reset_tbl(input string req);
        for (int p = 0; p < N; p++)
            check(req, redir_tbl[p*64 +: 64], 64'h0001_0000_0001_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check_reset_tbl("R9");
        bus_addr = 8'h00; bus_size = 2'd2; #1;
        check("R2", {32'h0, bus_rdata}, 64'h0);

        for (int i = 0; i < NV; i++)
            access(VECS[i].we, VECS[i].addr, VECS[i].size, VECS[i].data, VECS[i].data,
                   $sformatf("R%0d", VECS[i].req));

        // R7 and R10: final table contents after the vector walk.
        #1;
        check("R7", redir_tbl[0 +: 64], 64'hAB00_0000_0000_0031);
        check("R7", redir_tbl[15*64 +: 64], 64'h1234_5678_0001_0000);
        for (int p = 1; p < N - 1; p++)
            check("R10", redir_tbl[p*64 +: 64], 64'h0001_0000_0001_0000);

        // R11: a window write and a read of the same half in one cycle.
        access(1'b1, 8'h00, 2'd2, 32'h0000_0012, 32'h0, "R11");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h10; bus_size = 2'd2; bus_wdata = 32'h0000_0077;
        #5;
        check("R11", {32'h0, bus_rdata}, 64'h0001_0000);
        check("R11", redir_tbl[64 +: 64], 64'h0001_0000_0001_0000);
        @(negedge clk);
        bus_we = 1'b0;
        #5;
        check("R11", {32'h0, bus_rdata}, 64'h0000_0077);
        check("R11", redir_tbl[64 +: 64], 64'h0001_0000_0000_0077);

        // R4 and R9: a reset in mid-run restores the table, select and identifier.
        access(1'b1, 8'h00, 2'd2, 32'h0000_0000, 32'h0, "R4");
        access(1'b1, 8'h10, 2'd2, 32'h0500_0000, 32'h0, "R4");
        access(1'b0, 8'h10, 2'd2, 32'h0, 32'h0500_0000, "R4");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check_reset_tbl("R9");
        access(1'b0, 8'h00, 2'd2, 32'h0, 32'h0, "R2");
        access(1'b0, 8'h10, 2'd2, 32'h0, 32'h0, "R4");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule